// File: doc/BRIEF.md
# Keyboard and Cassette Port Glue

This block sits behind a byte-wide, four-register parallel port and turns it into the keyboard and cassette glue of a small home computer. The CPU writes a control byte that selects one row of an 11-row by 8-column keyboard matrix and sets the cassette motor relay, the cassette write level and two key-click pulse bits. It then reads back the column status of the selected row. One row is merged with a second key source.

A status register gathers the two joystick triggers, the cassette presence flag and the digitised cassette read bit into one byte. The two click bits are turned into a small DAC code. The port's mode register holds its reset value and is otherwise only stored. Matrix inputs are active low, so a pressed key reads as 0.

Top module: `kbd_tape_glue`

## Requirements
- R1: The output register at address 2 loads `wr_data` on the rising clock edge where `wr_en` is high, and its effect is visible on the outputs after that edge. A synchronous reset (`rst_n` low at an edge) clears it to 0x00. `kbd_row` equals its bits 3:0.
- R2: With the selected row in 0..10 (other than 6), a read of address 1 returns that row's 8-bit slice of `key_rows`. Row r occupies bits r*8+7..r*8.
- R3: With a selected row of 11 to 15, a read of address 1 returns 0xFF.
- R4: With row 6 selected, a read of address 1 returns the bitwise AND of row 6 and `aux_keys`.
- R5: A read of address 0 returns bits 3:0 = 1111, bits 5:4 = `trig[1:0]`, bit 6 = NOT `tape_present`, and bit 7 = `tape_rd`.
- R6: `tape_motor_n` equals output-register bit 4, where 1 means motor off and 0 means motor on.
- R7: `tape_wr_neg` equals output-register bit 5, where 1 selects the negative write level and 0 the positive level.
- R8: `click_dac` equals 0x3E times the number of set bits among output-register bits 6 and 7, giving 0x00, 0x3E or 0x7C.
- R9: The mode register at address 3 reads 0x92 after reset. It stores bytes written to address 3, and those writes leave the output register unchanged.
- R10: Writes to addresses 0 and 1 have no effect, and the output register keeps its value.
- R11: A read of address 2 returns the current output-register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 2 | Register address (0 status, 1 columns, 2 output, 3 mode) |
| wr_data | input | 8 | CPU write byte |
| rd_data | output | 8 | CPU read byte for `addr` |
| key_rows | input | 88 | Matrix columns, 8 bits per row, active low |
| aux_keys | input | 8 | Extra key source merged into row 6 |
| trig | input | 2 | Joystick trigger inputs |
| tape_present | input | 1 | Cassette inserted |
| tape_rd | input | 1 | Digitised cassette read data |
| kbd_row | output | 4 | Selected keyboard row |
| tape_motor_n | output | 1 | Motor relay, 1 = off |
| tape_wr_neg | output | 1 | Write level, 1 = negative |
| click_dac | output | 8 | Key-click DAC code |

## Verification
The row select walks through all sixteen codes, so the in-range rows, the merged row 6 and the out-of-range codes that force 0xFF are each told apart. Every row carries a distinct byte, so a row that is decoded wrong shows up. The click bits are driven through all four combinations to separate the one-pulse and two-pulse DAC levels. Writes to the status, column and mode addresses are placed between output-register writes, which shows that only address 2 changes the outputs. The status byte is read with the trigger, presence and read inputs toggled on their own.

// File: rtl/kbd_tape_pkg.sv
// Shared constants for the keyboard and cassette port glue.
package kbd_tape_pkg;
    localparam int          KT_NUM_ROWS  = 11;
    localparam int          KT_COL_W     = 8;
    localparam int          KT_ROW_SEL_W = 4;
    localparam int          KT_MERGE_ROW = 6;
    localparam logic [7:0]  KT_CLICK_STEP = 8'h3E;
    localparam logic [7:0]  KT_MODE_RESET = 8'h92;

    typedef enum logic [1:0] {
        KT_ADDR_STATUS = 2'd0,
        KT_ADDR_COLS   = 2'd1,
        KT_ADDR_OUT    = 2'd2,
        KT_ADDR_MODE   = 2'd3
    } kt_addr_e;
endpackage

// File: rtl/kt_row_decoder.sv
// Selects one matrix row and returns its column byte.
// Assumes active-low columns; out-of-range rows read as all ones (no key).
module kt_row_decoder
    import kbd_tape_pkg::*;
#(
    parameter int NUM_ROWS  = KT_NUM_ROWS,
    parameter int COL_W     = KT_COL_W,
    parameter int ROW_SEL_W = KT_ROW_SEL_W,
    parameter int MERGE_ROW = KT_MERGE_ROW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ROW_SEL_W-1:0]      row_sel,
    input  logic [NUM_ROWS*COL_W-1:0] rows_flat,
    input  logic [COL_W-1:0]          aux_cols,
    output logic [COL_W-1:0]          col_byte
);
    logic [COL_W-1:0] row_arr [NUM_ROWS];

    // Unpack the flat matrix bus into one entry per row.
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_unpack
        assign row_arr[g] = rows_flat[g*COL_W +: COL_W];
    end

    // Pick the addressed row; a merged row is ANDed with the extra source.
    always_comb begin
        col_byte = '1;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (row_sel == ROW_SEL_W'(i)) begin
                col_byte = row_arr[i];
                if (i == MERGE_ROW) col_byte = row_arr[i] & aux_cols;
            end
        end
    end

    p_bad_row_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel >= ROW_SEL_W'(NUM_ROWS)) |-> (col_byte == '1));
    p_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel == ROW_SEL_W'(MERGE_ROW)) |-> ((col_byte & ~aux_cols) == '0));
endmodule

// File: rtl/kt_status_byte.sv
// Assembles the status byte from trigger and cassette inputs.
// Assumes the cassette comparator is already a clean digital bit.
module kt_status_byte (
    input  logic [1:0] trig,
    input  logic       tape_present,
    input  logic       tape_rd,
    output logic [7:0] status
);
    // Fixed ones in the low nibble, triggers, active-low ready, read data.
    always_comb status = {tape_rd, ~tape_present, trig, 4'hF};
endmodule

// File: rtl/kt_out_port.sv
// Holds the output and mode registers and decodes the output bits.
// Assumes a single-cycle write strobe; reset is synchronous, active low.
module kt_out_port
    import kbd_tape_pkg::*;
#(
    parameter int         ROW_SEL_W  = KT_ROW_SEL_W,
    parameter logic [7:0] CLICK_STEP = KT_CLICK_STEP,
    parameter logic [7:0] MODE_RESET = KT_MODE_RESET
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [7:0]           wr_data,
    output logic [7:0]           out_reg,
    output logic [7:0]           mode_reg,
    output logic [ROW_SEL_W-1:0] row_sel,
    output logic                 motor_n,
    output logic                 wr_neg,
    output logic [7:0]           dac
);
    // Output register: loads on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    out_reg <= 8'h00;
        else if (wr_en && addr == KT_ADDR_OUT)         out_reg <= wr_data;
    end

    // Mode register: holds the reset value until the CPU rewrites it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    mode_reg <= MODE_RESET;
        else if (wr_en && addr == KT_ADDR_MODE)        mode_reg <= wr_data;
    end

    // Field decode of the output register.
    always_comb begin
        row_sel = out_reg[ROW_SEL_W-1:0];
        motor_n = out_reg[4];
        wr_neg  = out_reg[5];
        dac     = (out_reg[6] ? CLICK_STEP : 8'h00) + (out_reg[7] ? CLICK_STEP : 8'h00);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (out_reg == 8'h00));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr != KT_ADDR_OUT) |=> $stable(out_reg));
    p_dac_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dac == 8'h00) || (dac == CLICK_STEP) || (dac == 8'(CLICK_STEP * 2)));
    p_motor_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == KT_ADDR_OUT) |=> (motor_n == $past(wr_data[4])));
endmodule

// File: rtl/kbd_tape_glue.sv
// Keyboard matrix and cassette glue behind a four-register byte port.
// Assumes combinational reads; writes take effect at the strobed clock edge.
module kbd_tape_glue
    import kbd_tape_pkg::*;
#(
    parameter int NUM_ROWS  = KT_NUM_ROWS,
    parameter int COL_W     = KT_COL_W,
    parameter int ROW_SEL_W = KT_ROW_SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                addr,
    input  logic [7:0]                wr_data,
    output logic [7:0]                rd_data,
    input  logic [NUM_ROWS*COL_W-1:0] key_rows,
    input  logic [COL_W-1:0]          aux_keys,
    input  logic [1:0]                trig,
    input  logic                      tape_present,
    input  logic                      tape_rd,
    output logic [ROW_SEL_W-1:0]      kbd_row,
    output logic                      tape_motor_n,
    output logic                      tape_wr_neg,
    output logic [7:0]                click_dac
);
    logic [7:0]       out_reg, mode_reg, status;
    logic [COL_W-1:0] col_byte;

    kt_out_port #(.ROW_SEL_W(ROW_SEL_W)) u_out (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .out_reg(out_reg), .mode_reg(mode_reg), .row_sel(kbd_row),
        .motor_n(tape_motor_n), .wr_neg(tape_wr_neg), .dac(click_dac)
    );

    kt_row_decoder #(.NUM_ROWS(NUM_ROWS), .COL_W(COL_W), .ROW_SEL_W(ROW_SEL_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .row_sel(kbd_row), .rows_flat(key_rows),
        .aux_cols(aux_keys), .col_byte(col_byte)
    );

    kt_status_byte u_stat (
        .trig(trig), .tape_present(tape_present), .tape_rd(tape_rd), .status(status)
    );

    // Read multiplexer over the four register addresses.
    always_comb begin
        unique case (addr)
            KT_ADDR_STATUS: rd_data = status;
            KT_ADDR_COLS:   rd_data = 8'(col_byte);
            KT_ADDR_OUT:    rd_data = out_reg;
            default:        rd_data = mode_reg;
        endcase
    end
endmodule

// File: tb/kbd_tape_glue_tb.sv
module kbd_tape_glue_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  addr = 0;
    logic [7:0]  wr_data = 0;
    logic [7:0]  rd_data;
    logic [87:0] key_rows = '1;
    logic [7:0]  aux_keys = 8'hFF;
    logic [1:0]  trig = 0;
    logic        tape_present = 0;
    logic        tape_rd = 0;
    logic [3:0]  kbd_row;
    logic        tape_motor_n, tape_wr_neg;
    logic [7:0]  click_dac;

    int n_tests = 0, n_fail = 0;
    int m_out = 0, m_mode = 8'h92;
    bit done = 0;

    kbd_tape_glue u_dut (.*);

    always #5 clk = ~clk;

    // Behavioural reference registers.
    always @(posedge clk) begin
        if (!rst_n) begin m_out <= 0; m_mode <= 8'h92; end
        else if (wr_en && addr == 2) m_out <= wr_data;
        else if (wr_en && addr == 3) m_mode <= wr_data;
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_cols(int row);
        int v;
        if (row > 10) return 8'hFF;
        v = key_rows[row*8 +: 8];
        if (row == 6) v = v & aux_keys;
        return v;
    endfunction

    // Compare every output with the model each cycle, away from the edge.
    always begin
        @(posedge clk); #3;
        if (rst_n && !done) begin
            int row, clicks;
            row = m_out & 15;
            clicks = ((m_out >> 6) & 1) + ((m_out >> 7) & 1);
            chk("R1 row", kbd_row, row);
            chk("R6 motor", tape_motor_n, (m_out >> 4) & 1);
            chk("R7 write", tape_wr_neg, (m_out >> 5) & 1);
            chk("R8 dac", click_dac, clicks * 8'h3E);
            case (addr)
                0: chk("R5 status", rd_data, 8'h0F | (trig << 4) | ((tape_present ? 0 : 1) << 6) | (tape_rd << 7));
                1: chk(row > 10 ? "R3 cols" : (row == 6 ? "R4 cols" : "R2 cols"), rd_data, exp_cols(row));
                2: chk("R11 out", rd_data, m_out);
                default: chk("R9 mode", rd_data, m_mode);
            endcase
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk); wr_en = 1; addr = 2'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic look(int a, int cycles);
        @(negedge clk); addr = 2'(a);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        for (int r = 0; r < 11; r++) key_rows[r*8 +: 8] = 8'((r * 37 + 5) ^ 8'hA5);
        aux_keys = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1/R9 reset state
        look(2, 1);
        look(3, 1);
        // R2 R3 R4: walk every row code
        for (int r = 0; r < 16; r++) begin
            wr(2, r);
            look(1, 1);
        end
        // R4 with other merge sources
        wr(2, 6);
        aux_keys = 8'hFF; look(1, 1);
        aux_keys = 8'h00; look(1, 1);
        key_rows[6*8 +: 8] = 8'h0F; aux_keys = 8'h3C; look(1, 1);
        // R6 R7 R8: every combination of the upper bits
        for (int h = 0; h < 16; h++) begin
            wr(2, (h << 4) | 3);
            look(2, 1);
        end
        // R10: writes to status/column addresses are ignored
        wr(2, 8'hD7);
        wr(0, 8'h00); look(2, 1);
        wr(1, 8'h28); look(2, 1);
        // R9: mode write stored, output register untouched
        wr(3, 8'h9B); look(3, 1); look(2, 1);
        // R5: status bits
        for (int s = 0; s < 16; s++) begin
            trig = 2'(s); tape_present = s[2]; tape_rd = s[3];
            look(0, 1);
        end
        // R1: synchronous reset clears the output register
        wr(2, 8'hFF);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        look(2, 2);
        look(3, 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule